// File: doc/BRIEF.md
# Prescaled Timer Counter with Software Event Requests

This block is a general-purpose timer core. A prescaler divides the clock by a programmable ratio and produces count ticks. A 16-bit counter advances on those ticks in one of three directions: upward, downward, or center-aligned (up and down alternately). Two channels sit beside the counter. A channel set to an input mode can copy the counter value into its own capture register.

Software drives the block through a plain word-wide register port. Writes are taken on the clock edge while `bus_we` is high. Reads are combinational from `bus_addr`. The port carries only control and status, so it has no valid/ready handshake.

Software can request events by writing the event register:
- An update request restarts the count and the prescaler.
- A per-channel request forces a capture.

Each request bit is a one-cycle pulse that hardware clears by itself. While a channel is enabled, its mode field is locked.

Register word addresses:

| Address | Register |
|---|---|
| 0 | control: bit 0 run, bits 2:1 direction |
| 1 | prescaler value |
| 2 | reload value |
| 3 | counter (read) |
| 4 | event requests |
| 5 | channel control |
| 6 | channel enables: bit i enables channel i |
| 7 | status |
| 8 | capture value, channel 0 |
| 9 | capture value, channel 1 |

Top module: `gptimer_core`

## Requirements
- R1: The event register (address 4) holds bit 0 as the update request and bit 1+i as the capture request of channel i. Each bit acts in the cycle after the write, and the register then reads back as 0 with no further write.
- R2: An update request in up (direction 0) or center-aligned (direction 2) mode sets the counter to 0. Center-aligned counting then resumes upward.
- R3: An update request in down mode (direction 1) loads the counter with the reload value.
- R4: An update request clears the prescaler count. The first count tick then follows exactly prescaler+1 cycles after the update.
- R5: A capture request on a channel whose mode field is nonzero (input) copies the counter into that channel's capture register and sets its capture flag. With mode field 0 (output), the request changes nothing.
- R6: A capture on a channel whose capture flag is already set also sets that channel's overcapture flag.
- R7: A write to a channel's mode field (bits 1:0 of its byte) while that channel is enabled is ignored, and the field keeps its old value.
- R8: Channel control gives channel i bits 8i+7:8i. The remaining bits of a byte above the mode field stay writable whatever the enable state. Bits 31:16 read as 0.
- R9: Up mode counts from 0 to the reload value and wraps to 0. Down mode counts from the reload value to 0 and wraps back to the reload value. Center-aligned mode turns down at the reload value and up at 0.
- R10: While run (control bit 0) is set, the counter advances once every prescaler+1 clock cycles.
- R11: In the status register, bit i is channel i's capture flag and bit 2+i is its overcapture flag. Writing 0 to a bit clears it, and writing 1 leaves it unchanged.
- R12: When an update and a capture are requested in the same write, the capture stores the counter value held before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| bus_we | input | 1 | register write strobe |
| bus_addr | input | 4 | register word address |
| bus_wdata | input | 32 | write data |
| bus_rdata | output | 32 | read data for bus_addr |

## Verification
An update and a capture can land in the same cycle when one event write sets bit 0 together with a channel's capture bit. The bench first parks the counter at a known nonzero value by using a down-mode update with the counter stopped. It then switches to up mode and issues the combined request. The capture register must hold the parked value while the counter reads 0. A second collision arises when a capture arrives while the previous flag is still pending; that case is judged through the overcapture bit.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 4;

  typedef enum logic [1:0] {
    DIR_UP     = 2'd0,
    DIR_DOWN   = 2'd1,
    DIR_CENTER = 2'd2
  } dir_e;

  localparam logic [ADDR_W-1:0] A_CTRL   = 4'd0;
  localparam logic [ADDR_W-1:0] A_PRESC  = 4'd1;
  localparam logic [ADDR_W-1:0] A_RELOAD = 4'd2;
  localparam logic [ADDR_W-1:0] A_COUNT  = 4'd3;
  localparam logic [ADDR_W-1:0] A_EVENT  = 4'd4;
  localparam logic [ADDR_W-1:0] A_CHCTL  = 4'd5;
  localparam logic [ADDR_W-1:0] A_CHEN   = 4'd6;
  localparam logic [ADDR_W-1:0] A_STATUS = 4'd7;
  localparam logic [ADDR_W-1:0] A_CAP0   = 4'd8;
endpackage

// File: rtl/gpt_prescaler.sv
module gpt_prescaler #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         clear,
  input  logic [W-1:0] div,
  output logic         tick
);
  logic [W-1:0] pcnt;

  assign tick = run && !clear && (pcnt == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pcnt <= '0;
    else if (clear) pcnt <= '0;
    else if (run)   pcnt <= tick ? '0 : pcnt + 1'b1;
  end

  AST_PSC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (pcnt == '0)); // R4
endmodule

// File: rtl/gpt_counter.sv
module gpt_counter
  import gpt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         upd,
  input  logic [1:0]   dir,
  input  logic [W-1:0] reload,
  output logic [W-1:0] cnt
);
  logic going_down;
  dir_e d;
  assign d = dir_e'(dir);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      going_down <= 1'b0;
    end else if (upd) begin
      cnt        <= (d == DIR_DOWN) ? reload : '0;
      going_down <= 1'b0;
    end else if (tick) begin
      case (d)
        DIR_DOWN: cnt <= (cnt == '0) ? reload : cnt - 1'b1;
        DIR_CENTER: begin
          if (!going_down) begin
            if (cnt >= reload) begin
              going_down <= 1'b1;
              cnt        <= (cnt == '0) ? '0 : cnt - 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end else if (cnt == '0) begin
            going_down <= 1'b0;
            cnt        <= (reload == '0) ? '0 : W'(1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: cnt <= (cnt >= reload) ? '0 : cnt + 1'b1;
      endcase
    end
  end

  AST_UPD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && dir != 2'd1) |=> (cnt == '0)); // R2
  AST_UPD_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && dir == 2'd1) |=> (cnt == $past(reload))); // R3
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd && !tick) |=> $stable(cnt)); // R10
endmodule

// File: rtl/gpt_channel.sv
module gpt_channel #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         ctl_we,
  input  logic [7:0]   ctl_wbyte,
  output logic [7:0]   ctl,
  input  logic         cap_req,
  input  logic [W-1:0] cnt,
  input  logic         stat_we,
  input  logic         keep_flag,
  input  logic         keep_over,
  output logic [W-1:0] capv,
  output logic         flag,
  output logic         over
);
  logic cap;
  assign cap = cap_req && (ctl[1:0] != 2'b00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= '0;
    end else if (ctl_we) begin
      ctl[7:2] <= ctl_wbyte[7:2];
      if (!en) ctl[1:0] <= ctl_wbyte[1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      capv <= '0;
      flag <= 1'b0;
      over <= 1'b0;
    end else begin
      if (cap) capv <= cnt;
      if (cap)          flag <= 1'b1;
      else if (stat_we) flag <= flag & keep_flag;
      if (cap && flag)  over <= 1'b1;
      else if (stat_we) over <= over & keep_over;
    end
  end

  AST_CAP_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> (capv == $past(cnt) && flag)); // R5
  AST_OVERCAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (cap && flag) |=> over); // R6
  AST_MODE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> $stable(ctl[1:0])); // R7
endmodule

// File: rtl/gptimer_core.sv
module gptimer_core
  import gpt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam int EV_W  = NUM_CH + 1;
  localparam int CTL_W = 8 * NUM_CH;

  logic             run;
  logic [1:0]       dir;
  logic [CNT_W-1:0] presc, reload, cnt;
  logic [NUM_CH-1:0] chen;
  logic [EV_W-1:0]  ev;
  logic             tick, ev_wr;
  logic [CTL_W-1:0] ctl_all;
  logic [NUM_CH-1:0] flags, overs;
  logic [CNT_W-1:0] capv [NUM_CH];

  assign ev_wr = bus_we && (bus_addr == A_EVENT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= 1'b0;
      dir    <= 2'd0;
      presc  <= '0;
      reload <= '0;
      chen   <= '0;
      ev     <= '0;
    end else begin
      ev <= ev_wr ? bus_wdata[EV_W-1:0] : '0;
      if (bus_we) begin
        case (bus_addr)
          A_CTRL:   begin run <= bus_wdata[0]; dir <= bus_wdata[2:1]; end
          A_PRESC:  presc  <= bus_wdata[CNT_W-1:0];
          A_RELOAD: reload <= bus_wdata[CNT_W-1:0];
          A_CHEN:   chen   <= bus_wdata[NUM_CH-1:0];
          default:  ;
        endcase
      end
    end
  end

  gpt_prescaler #(.W(CNT_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .run(run), .clear(ev[0]), .div(presc), .tick(tick)
  );

  gpt_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .upd(ev[0]), .dir(dir),
    .reload(reload), .cnt(cnt)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    gpt_channel #(.W(CNT_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .en(chen[i]),
      .ctl_we(bus_we && bus_addr == A_CHCTL),
      .ctl_wbyte(bus_wdata[8*i +: 8]),
      .ctl(ctl_all[8*i +: 8]),
      .cap_req(ev[i+1]), .cnt(cnt),
      .stat_we(bus_we && bus_addr == A_STATUS),
      .keep_flag(bus_wdata[i]), .keep_over(bus_wdata[NUM_CH+i]),
      .capv(capv[i]), .flag(flags[i]), .over(overs[i])
    );
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL:   bus_rdata = DATA_W'({dir, run});
      A_PRESC:  bus_rdata = DATA_W'(presc);
      A_RELOAD: bus_rdata = DATA_W'(reload);
      A_COUNT:  bus_rdata = DATA_W'(cnt);
      A_EVENT:  bus_rdata = DATA_W'(ev);
      A_CHCTL:  bus_rdata = DATA_W'(ctl_all);
      A_CHEN:   bus_rdata = DATA_W'(chen);
      A_STATUS: bus_rdata = DATA_W'({overs, flags});
      default: begin
        for (int i = 0; i < NUM_CH; i++)
          if (bus_addr == A_CAP0 + ADDR_W'(i)) bus_rdata = DATA_W'(capv[i]);
      end
    endcase
  end

  AST_EVENT_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ev != '0 && !ev_wr) |=> (ev == '0)); // R1
endmodule

// File: tb/tb_gptimer_core.sv
module tb_gptimer_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  int compared = 0;
  int mismatched = 0;

  always #2 clk = ~clk;

  gptimer_core dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic chk(input string req, input logic [3:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    compared++;
    if (bus_rdata !== exp) begin
      mismatched++;
      $display("FAIL %s addr %0d actual %0h expected %0h", req, a, bus_rdata, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state
    for (int a = 0; a < 10; a++) chk("reset", 4'(a), 32'h0);

    // R9 R10 R2 R3 R4: sweep of prescaler, reload and direction
    for (int p = 0; p < 3; p++)
      for (int r = 1; r < 5; r++)
        for (int m = 0; m < 3; m++) begin
          wr(4'd0, 32'(1 | (m << 1)));
          wr(4'd1, 32'(p));
          wr(4'd2, 32'(r));
          wr(4'd4, 32'h1);
          for (int c = 0; c < 21; c++) begin
            int t, e;
            @(negedge clk);
            t = c / (p + 1);
            if (m == 0)      e = t % (r + 1);
            else if (m == 1) e = r - (t % (r + 1));
            else begin
              e = t % (2 * r);
              if (e > r) e = 2 * r - e;
            end
            chk("R9/R10/R2/R3/R4 count sweep", 4'd3, 32'(e));
          end
        end

    // R1: request bits read back as zero after the acting cycle
    chk("R1 event register cleared", 4'd4, 32'h0);

    // R3: counter stopped, down-mode update parks it at reload
    wr(4'd0, 32'h2);
    wr(4'd2, 32'd123);
    wr(4'd4, 32'h1);
    @(negedge clk);
    chk("R3 park at reload", 4'd3, 32'd123);

    // R8 R7: channel control layout and mode lock
    wr(4'd5, 32'hFFFF_FFFF);
    chk("R8 upper bits zero", 4'd5, 32'h0000_FFFF);
    wr(4'd5, 32'h0000_00F1);
    chk("R8 channel bytes", 4'd5, 32'h0000_00F1);
    wr(4'd6, 32'h1);
    wr(4'd5, 32'h0000_00A2);
    chk("R7 mode locked while enabled", 4'd5, 32'h0000_00A1);
    wr(4'd6, 32'h0);
    wr(4'd5, 32'h0000_00F1);
    chk("R7 mode writable when disabled", 4'd5, 32'h0000_00F1);

    // R5: capture on input channel 0, none on output channel 1
    wr(4'd4, 32'h2);
    @(negedge clk);
    chk("R1 capture bit cleared", 4'd4, 32'h0);
    chk("R5 capture value ch0", 4'd8, 32'd123);
    chk("R5 flag ch0", 4'd7, 32'h1);
    wr(4'd4, 32'h4);
    @(negedge clk);
    chk("R5 output channel no capture", 4'd9, 32'h0);
    chk("R5 output channel no flag", 4'd7, 32'h1);

    // R6: second capture with flag pending
    wr(4'd4, 32'h2);
    @(negedge clk);
    chk("R6 overcapture", 4'd7, 32'h5);

    // R11: write one keeps, write zero clears
    wr(4'd7, 32'hFFFF_FFFF);
    chk("R11 write one keeps", 4'd7, 32'h5);
    wr(4'd7, 32'hFFFF_FFFB);
    chk("R11 clear overcapture only", 4'd7, 32'h1);
    wr(4'd7, 32'h0);
    chk("R11 all cleared", 4'd7, 32'h0);

    // R12: update and capture together, capture sees pre-update count
    wr(4'd2, 32'd77);
    wr(4'd4, 32'h1);
    wr(4'd0, 32'h0);
    wr(4'd4, 32'h3);
    @(negedge clk);
    chk("R12 capture pre-update value", 4'd8, 32'd77);
    chk("R12 R2 counter cleared", 4'd3, 32'h0);
    chk("R12 flag without overcapture", 4'd7, 32'h1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule